// File: doc/BRIEF.md
# Immediate-Shift Operand Unit with Flags

This block forms the second operand of a data-processing operation from a source word and an immediate shift descriptor. A two-bit kind selects logical left, logical right, arithmetic right or rotate right. A five-bit field carries the amount modulo the word width. The unit decodes that pair into the operation it really stands for. A zero field means a full-width shift for the two right shifts, and it means a one-bit rotate through the carry for rotate. The unit then computes the shifted word and the shifter carry-out.

The result and carry-out are registered. A set of N, Z, C and V flags sits beside them. On the same clock edge these flags are written from the new result, but only when the caller requests flag setting and the destination is not the program counter. The incoming carry comes from the surrounding pipeline. It feeds the zero-amount and rotate-through-carry cases.

Top module: `shift_operand_unit`

## Requirements
- R1: Kind 00 is logical left. For a field n in 1..31 the result is the source shifted left by n with zeros filled in, and the carry-out is source bit 32-n.
- R2: Kind 00 with field 0 passes the source through unchanged, and the carry-out equals the incoming carry.
- R3: Kind 01 is logical right. For a field n in 1..31 the result is the source shifted right by n with zeros filled in, and the carry-out is source bit n-1.
- R4: Kind 10 is arithmetic right. For a field n in 1..31 the result is the source shifted right by n with bit 31 copied into the vacated positions, and the carry-out is source bit n-1.
- R5: Kind 01 with field 0 means a shift of 32. The result is zero and the carry-out is source bit 31.
- R6: Kind 10 with field 0 means a shift of 32. Every result bit equals source bit 31, and the carry-out is source bit 31.
- R7: Kind 11 is rotate right. For a field n in 1..31 the result is the source rotated right by n, and the carry-out is source bit n-1, which is result bit 31.
- R8: Kind 11 with field 0 is a rotate right by one through carry. The result is the incoming carry in bit 31 above source bits 31..1, and the carry-out is source bit 0.
- R9: When flags are written, N takes result bit 31, Z is 1 exactly when the result is zero, C takes the carry-out, and V keeps its value.
- R10: Flags are written only when the set-flags input is 1 and the destination-is-PC input is 0. Otherwise N, Z and C hold their values.
- R11: A synchronous active-high reset clears the result, the carry-out and all four flags to zero.
- R12: The result, carry-out and flags reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Source operand |
| sh_kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| sh_field_i | input | 5 | Immediate shift amount modulo 32 |
| set_flags_i | input | 1 | Request to write the flags |
| dest_pc_i | input | 1 | Destination is the program counter, which suppresses the flag write |
| carry_i | input | 1 | Current carry flag from the pipeline |
| res_o | output | 32 | Registered shifted result |
| shc_o | output | 1 | Registered shifter carry-out |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag, never modified after reset |

## Verification
On every cycle, the assertions check that the flags hold when a write is not enabled. When a write is enabled, they check that N, Z and C agree with the registered result and carry-out. They also check the three zero-field cases: pass-through, the full-width logical right shift and the rotate through carry. Only the bench scenarios can show the correct shifted value and carry bit for each nonzero amount under the other kinds. The same holds for the arithmetic sign fill, V staying unchanged, and the reset values. The bench compares each of these against an independent bit-by-bit model.

// File: rtl/sou_pkg.sv
package sou_pkg;
  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } sh_kind_e;

  typedef enum logic [2:0] {
    OP_LSL,
    OP_LSR,
    OP_ASR,
    OP_ROR,
    OP_RRX
  } sh_op_e;
endpackage

// File: rtl/sou_decode.sv
module sou_decode
  import sou_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  sh_kind_e        kind_i,
  input  logic [AW-1:0]   field_i,
  output sh_op_e          op_o,
  output logic [AW:0]     amt_o
);
  localparam logic [AW:0] FULL = (AW+1)'(W);

  logic field_zero;
  assign field_zero = (field_i == '0);

  always_comb begin
    amt_o = {1'b0, field_i};
    unique case (kind_i)
      KIND_LSL: op_o = OP_LSL;
      KIND_LSR: begin
        op_o = OP_LSR;
        if (field_zero) amt_o = FULL;
      end
      KIND_ASR: begin
        op_o = OP_ASR;
        if (field_zero) amt_o = FULL;
      end
      default: begin
        op_o = field_zero ? OP_RRX : OP_ROR;
        if (field_zero) amt_o = (AW+1)'(1);
      end
    endcase
  end
endmodule

// File: rtl/sou_shift.sv
module sou_shift
  import sou_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0] src_i,
  input  sh_op_e       op_i,
  input  logic [AW:0]  amt_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam logic [AW:0] FULL = (AW+1)'(W);

  logic [W:0]   left_ext;
  logic [W:0]   lright_ext;
  logic [W:0]   aright_ext;
  logic [W-1:0] rot;
  logic [AW:0]  back_amt;

  assign back_amt   = FULL - amt_i;
  assign left_ext   = {1'b0, src_i} << amt_i;
  assign lright_ext = {src_i, 1'b0} >> amt_i;
  assign aright_ext = $unsigned($signed({src_i, 1'b0}) >>> amt_i);
  assign rot        = (src_i >> amt_i) | (src_i << back_amt);

  always_comb begin
    unique case (op_i)
      OP_LSL: begin
        res_o  = left_ext[W-1:0];
        cout_o = (amt_i == '0) ? cin_i : left_ext[W];
      end
      OP_LSR: begin
        res_o  = lright_ext[W:1];
        cout_o = lright_ext[0];
      end
      OP_ASR: begin
        res_o  = aright_ext[W:1];
        cout_o = aright_ext[0];
      end
      OP_ROR: begin
        res_o  = rot;
        cout_o = rot[W-1];
      end
      default: begin
        res_o  = {cin_i, src_i[W-1:1]};
        cout_o = src_i[0];
      end
    endcase
  end
endmodule

// File: rtl/sou_flags.sv
module sou_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic [W-1:0] res_i,
  input  logic         cout_i,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      n_o <= 1'b0;
      z_o <= 1'b0;
      c_o <= 1'b0;
      v_o <= 1'b0;
    end else if (wr_en_i) begin
      n_o <= res_i[W-1];
      z_o <= (res_i == '0);
      c_o <= cout_i;
    end
  end

  // R10: without a write enable the flags keep their values
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable({n_o, z_o, c_o}));
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import sou_pkg::*;
#(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src_i,
  input  logic [1:0]    sh_kind_i,
  input  logic [AW-1:0] sh_field_i,
  input  logic          set_flags_i,
  input  logic          dest_pc_i,
  input  logic          carry_i,
  output logic [W-1:0]  res_o,
  output logic          shc_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_c_o,
  output logic          flag_v_o
);
  sh_op_e       op;
  logic [AW:0]  amt;
  logic [W-1:0] res_c;
  logic         cout_c;
  logic         wr_en;

  assign wr_en = set_flags_i && !dest_pc_i;

  sou_decode #(.W(W)) dec_i (
    .kind_i  (sh_kind_e'(sh_kind_i)),
    .field_i (sh_field_i),
    .op_o    (op),
    .amt_o   (amt)
  );

  sou_shift #(.W(W)) shf_i (
    .src_i  (src_i),
    .op_i   (op),
    .amt_i  (amt),
    .cin_i  (carry_i),
    .res_o  (res_c),
    .cout_o (cout_c)
  );

  sou_flags #(.W(W)) flg_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en),
    .res_i   (res_c),
    .cout_i  (cout_c),
    .n_o     (flag_n_o),
    .z_o     (flag_z_o),
    .c_o     (flag_c_o),
    .v_o     (flag_v_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      shc_o <= 1'b0;
    end else begin
      res_o <= res_c;
      shc_o <= cout_c;
    end
  end

  // R9: written flags agree with the registered result and carry-out
  assert_flags_match_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flag_n_o == res_o[W-1]) && (flag_z_o == (res_o == '0)) && (flag_c_o == shc_o));

  // R2: left shift by zero passes the operand and the carry through
  assert_lsl_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (sh_kind_i == 2'b00 && sh_field_i == '0) |=> (res_o == $past(src_i)) && (shc_o == $past(carry_i)));

  // R5: logical right with a zero field is a full-width shift
  assert_lsr_full_R5: assert property (@(posedge clk) disable iff (rst)
    (sh_kind_i == 2'b01 && sh_field_i == '0) |=> (res_o == '0) && (shc_o == $past(src_i[W-1])));

  // R8: rotate with a zero field goes through the carry
  assert_rrx_R8: assert property (@(posedge clk) disable iff (rst)
    (sh_kind_i == 2'b11 && sh_field_i == '0) |=> (res_o[W-1] == $past(carry_i)) && (shc_o == $past(src_i[0])));
endmodule

// File: tb/shift_operand_unit_tb_top.sv
module shift_operand_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic [1:0]  kind = '0;
  logic [4:0]  field = '0;
  logic        setf = 1'b0;
  logic        dpc = 1'b0;
  logic        cin = 1'b0;
  logic [31:0] res;
  logic        shc, fn, fz, fc, fv;

  int total = 0;
  int bad = 0;

  logic [37:0] exp_q[$];
  string       tag_q[$];
  logic        m_n = 0, m_z = 0, m_c = 0, m_v = 0;
  logic [31:0] lcg = 32'h1234_5678;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  shift_operand_unit dut_i (
    .clk(clk), .rst(rst), .src_i(src), .sh_kind_i(kind), .sh_field_i(field),
    .set_flags_i(setf), .dest_pc_i(dpc), .carry_i(cin),
    .res_o(res), .shc_o(shc), .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv)
  );

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] s, input logic [1:0] k, input logic [4:0] f,
                       input logic ci, output logic [31:0] r, output logic co);
    int n;
    n = int'(f);
    if (f == 0 && (k == 2'b01 || k == 2'b10)) n = 32;
    r = '0;
    co = ci;
    if (k == 2'b11 && f == 0) begin
      for (int i = 0; i < 31; i++) r[i] = s[i+1];
      r[31] = ci;
      co = s[0];
    end else begin
      for (int i = 0; i < 32; i++) begin
        case (k)
          2'b00: r[i] = (i >= n) ? s[i-n] : 1'b0;
          2'b01: r[i] = (i + n < 32) ? s[i+n] : 1'b0;
          2'b10: r[i] = (i + n < 32) ? s[i+n] : s[31];
          default: r[i] = s[(i+n)%32];
        endcase
      end
      if (k == 2'b00) begin
        if (n != 0) co = s[32-n];
      end else co = s[n-1];
    end
  endtask

  task automatic drive(input string tag, input logic [31:0] s, input logic [1:0] k,
                       input logic [4:0] f, input logic sf, input logic pc, input logic ci);
    logic [31:0] r;
    logic co;
    @(negedge clk);
    src = s; kind = k; field = f; setf = sf; dpc = pc; cin = ci;
    model(s, k, f, ci, r, co);
    if (sf && !pc) begin
      m_n = r[31]; m_z = (r == 0); m_c = co;
    end
    exp_q.push_back({r, co, m_n, m_z, m_c, m_v, 1'b0});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [37:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {res, shc, fn, fz, fc, fv, 1'b0}, e);
      end
    end
  end

  function automatic string kind_tag(input logic [1:0] k, input logic [4:0] f);
    if (k == 2'b00) return (f == 0) ? "R2" : "R1";
    if (k == 2'b01) return (f == 0) ? "R5" : "R3";
    if (k == 2'b10) return (f == 0) ? "R6" : "R4";
    return (f == 0) ? "R8" : "R7";
  endfunction

  initial begin : driver
    logic [31:0] pats[4];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: outputs cleared after reset
    check("R11 reset", {res, shc, fn, fz, fc, fv, 1'b0}, '0);
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hDEAD_BEEF; pats[3] = 32'h0000_0000;
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 32; f++)
        for (int p = 0; p < 4; p++)
          drive(kind_tag(2'(k), 5'(f)), pats[p], 2'(k), 5'(f), 1'b1, 1'b0, 1'(p & 1));
    // R9 flag combinations, V must stay 0
    drive("R9 zero", 32'h0000_0001, 2'b01, 5'd1, 1'b1, 1'b0, 1'b0);
    drive("R9 neg", 32'h8000_0000, 2'b10, 5'd4, 1'b1, 1'b0, 1'b0);
    drive("R9 carry", 32'h0000_0003, 2'b11, 5'd1, 1'b1, 1'b0, 1'b0);
    // R10: suppressed writes leave flags unchanged
    drive("R10 noset", 32'h0000_0000, 2'b00, 5'd0, 1'b0, 1'b0, 1'b0);
    drive("R10 destpc", 32'hFFFF_FFFF, 2'b01, 5'd0, 1'b1, 1'b1, 1'b1);
    drive("R10 both", 32'h0000_0000, 2'b11, 5'd0, 1'b0, 1'b1, 1'b1);
    // R12: back-to-back random vectors, one-cycle latency
    for (int i = 0; i < 200; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      drive("R12 random", lcg ^ {lcg[15:0], lcg[31:16]}, lcg[31:30], lcg[20:16],
            lcg[9], lcg[5] & lcg[6], lcg[12]);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin : finisher
    wait (done);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule